// File: doc/BRIEF.md
# Memory Ordering Queue with Store-to-Load Forwarding

This block keeps loads and stores in program order from the moment they are dispatched until they retire. Each instruction takes the slot at the tail when it is allocated. Its address, and for a store its data, arrive later through writeback ports that name the slot. Every cycle the queue picks at most one load to act on. It picks the oldest load whose ordering against older stores is settled. That load is either sent to the data cache or, when an older store writes the same address, given that store's data straight from the queue, so it never reaches the cache.

Stores leave the queue only when they retire from the head. On retirement the store's address and data are presented to the cache write port in the same cycle. A flush names a surviving slot and throws away everything younger than it, which pulls the tail back. The depth is half of the instruction window size parameter.

Top module: `mem_order_queue`

## Requirements
- R1: Allocation takes the slot at the tail, whose index is shown on `alloc_idx` during the request. Slots are handed out in increasing index order modulo the depth. A request while `full` is high is ignored. `empty` is high only when no slot is occupied, and `full` is high only when all slots are occupied. After reset the queue is empty.
- R2: An address or data writeback names a slot index. A writeback that names an unoccupied slot is dropped, and a newly allocated slot always starts with no address and no data.
- R3: A load is neither sent to the cache nor forwarded while any older store in the queue has an unknown address.
- R4: A load with a known address and no older store at the same address is offered on `ld_iss_*` with its slot and address. The offer holds until a cycle in which `ld_iss_ready` is high, and the load is complete after that cycle.
- R5: A load with an older store at the same address is never offered to the cache. It is completed through `fwd_*` in a single cycle, and the data comes from the youngest of the matching older stores.
- R6: When that youngest matching older store has no data yet, the load waits. It is not offered to the cache and it is not forwarded until that data is written.
- R7: At most one load is acted on per cycle, and the oldest ready load goes first.
- R8: `commit_valid` retires the head slot only if the head is retirable: a load that has completed, or a store with both address and data known. A retiring store appears on `st_wr_*` in that same cycle. A commit of a head that is not retirable is ignored, and `st_wr_valid` stays low.
- R9: A flush that names an occupied slot frees every slot younger than it, and the next allocation then gets the slot after the named one. In that cycle allocation, commit, cache offer and forwarding are all suppressed. A flush that names an unoccupied slot is ignored.
- R10: Stores younger than a load never hold that load back or supply data to it, even when their address is unknown or equal to the load's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocate one slot at the tail |
| alloc_is_store | input | 1 | 1 = store, 0 = load |
| alloc_idx | output | PTR_W | Slot that the next allocation receives |
| full | output | 1 | All slots occupied |
| empty | output | 1 | No slot occupied |
| addr_wb_valid | input | 1 | Address writeback strobe |
| addr_wb_idx | input | PTR_W | Slot receiving the address |
| addr_wb_addr | input | ADDR_W | Address value |
| data_wb_valid | input | 1 | Store data writeback strobe |
| data_wb_idx | input | PTR_W | Slot receiving the data |
| data_wb_data | input | DATA_W | Store data value |
| ld_iss_valid | output | 1 | A load is offered to the cache |
| ld_iss_idx | output | PTR_W | Slot of the offered load |
| ld_iss_addr | output | ADDR_W | Address of the offered load |
| ld_iss_ready | input | 1 | The cache accepts the offered load |
| fwd_valid | output | 1 | A load is completed from a store in the queue |
| fwd_idx | output | PTR_W | Slot of the forwarded load |
| fwd_data | output | DATA_W | Forwarded data |
| commit_valid | input | 1 | Retire the head slot if it is retirable |
| st_wr_valid | output | 1 | A store retires to the cache this cycle |
| st_wr_addr | output | ADDR_W | Address of the retiring store |
| st_wr_data | output | DATA_W | Data of the retiring store |
| flush_valid | input | 1 | Flush everything younger than `flush_idx` |
| flush_idx | input | PTR_W | Youngest slot that survives the flush |

## Verification
The assertions check on every cycle that occupancy agrees with the pointers, that the full and empty flags never hold together, and that forwarding and a cache offer never happen in the same cycle. They also check that an offer always targets an occupied, unfinished load, that a forward marks its load complete, that a retiring store advances the head, and that a flush moves the tail to just past the named slot. Which store supplies the data, and when a load must wait, can only be shown by the bench's scenarios. The bench sweeps every match pattern of three older stores against one load and derives the expected source, data and waiting cycles from that pattern. Oldest-first order, dropped writebacks, ignored commits and flush recovery are shown by short directed sequences.

// File: rtl/mq_pkg.sv
package mq_pkg;
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_ISSUE = 2'd1,
    ACT_FWD   = 2'd2
  } mq_act_e;
endpackage

// File: rtl/mq_ptr_ctl.sv
module mq_ptr_ctl #(
  parameter int DEPTH = 32,
  parameter int PTR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             flush_en,
  input  logic [PTR_W-1:0] flush_idx,
  output logic [PTR_W:0]   head_q,
  output logic [PTR_W:0]   tail_q,
  output logic             full,
  output logic             empty
);
  logic [PTR_W:0]   head_n, tail_n, occ;
  logic [PTR_W-1:0] keep_dist;

  assign occ   = tail_q - head_q;
  assign full  = (occ == (PTR_W+1)'(DEPTH));
  assign empty = (occ == '0);
  assign keep_dist = flush_idx - head_q[PTR_W-1:0];

  always_comb begin
    head_n = head_q;
    tail_n = tail_q;
    if (flush_en) begin
      tail_n = head_q + {1'b0, keep_dist} + 1'b1;
    end else begin
      if (push) tail_n = tail_q + 1'b1;
      if (pop)  head_n = head_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_n;
      tail_q <= tail_n;
    end
  end
endmodule

// File: rtl/mq_entry_array.sv
module mq_entry_array #(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int PTR_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [PTR_W-1:0]  alloc_idx,
  input  logic              alloc_st,
  input  logic              wa_en,
  input  logic [PTR_W-1:0]  wa_idx,
  input  logic [ADDR_W-1:0] wa_addr,
  input  logic              wd_en,
  input  logic [PTR_W-1:0]  wd_idx,
  input  logic [DATA_W-1:0] wd_data,
  input  logic              done_en,
  input  logic [PTR_W-1:0]  done_idx,
  input  logic              retire_en,
  input  logic [PTR_W-1:0]  retire_idx,
  input  logic [DEPTH-1:0]  clr_mask,
  output logic [DEPTH-1:0]  valid_o,
  output logic [DEPTH-1:0]  store_o,
  output logic [DEPTH-1:0]  addr_v_o,
  output logic [DEPTH-1:0]  data_v_o,
  output logic [DEPTH-1:0]  done_o,
  output logic [ADDR_W-1:0] addr_o [DEPTH],
  output logic [DATA_W-1:0] data_o [DEPTH]
);
  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic              v_q, st_q, av_q, dv_q, dn_q;
    logic              v_n, st_n, av_n, dv_n, dn_n;
    logic              hit_alloc, hit_wa, hit_wd;
    logic [ADDR_W-1:0] a_q;
    logic [DATA_W-1:0] d_q;

    always_comb begin
      hit_alloc = alloc_en && (alloc_idx == PTR_W'(e));
      hit_wa    = wa_en && (wa_idx == PTR_W'(e)) && v_q;
      hit_wd    = wd_en && (wd_idx == PTR_W'(e)) && v_q;
      v_n  = v_q;
      st_n = st_q;
      av_n = av_q;
      dv_n = dv_q;
      dn_n = dn_q;
      if (hit_wa) av_n = 1'b1;
      if (hit_wd) dv_n = 1'b1;
      if (done_en && (done_idx == PTR_W'(e))) dn_n = 1'b1;
      if (retire_en && (retire_idx == PTR_W'(e))) v_n = 1'b0;
      if (clr_mask[e]) v_n = 1'b0;
      if (hit_alloc) begin
        v_n  = 1'b1;
        st_n = alloc_st;
        av_n = 1'b0;
        dv_n = 1'b0;
        dn_n = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q  <= 1'b0;
        st_q <= 1'b0;
        av_q <= 1'b0;
        dv_q <= 1'b0;
        dn_q <= 1'b0;
      end else begin
        v_q  <= v_n;
        st_q <= st_n;
        av_q <= av_n;
        dv_q <= dv_n;
        dn_q <= dn_n;
      end
    end

    always_ff @(posedge clk) begin
      if (hit_wa) a_q <= wa_addr;
      if (hit_wd) d_q <= wd_data;
    end

    assign valid_o[e]  = v_q;
    assign store_o[e]  = st_q;
    assign addr_v_o[e] = av_q;
    assign data_v_o[e] = dv_q;
    assign done_o[e]   = dn_q;
    assign addr_o[e]   = a_q;
    assign data_o[e]   = d_q;
  end
endmodule

// File: rtl/mq_order_check.sv
module mq_order_check
  import mq_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int PTR_W  = 5
) (
  input  logic [PTR_W-1:0]  head_idx,
  input  logic [DEPTH-1:0]  valid,
  input  logic [DEPTH-1:0]  is_st,
  input  logic [DEPTH-1:0]  addr_v,
  input  logic [DEPTH-1:0]  data_v,
  input  logic [DEPTH-1:0]  done,
  input  logic [ADDR_W-1:0] addr [DEPTH],
  input  logic [DATA_W-1:0] data [DEPTH],
  output mq_act_e           act,
  output logic [PTR_W-1:0]  sel_idx,
  output logic [ADDR_W-1:0] sel_addr,
  output logic [DATA_W-1:0] sel_data
);
  logic [PTR_W-1:0] age [DEPTH];
  logic [PTR_W-1:0] src [DEPTH];
  logic [DEPTH-1:0] blocked, matched, ready;

  for (genvar g = 0; g < DEPTH; g++) begin : g_age
    assign age[g] = PTR_W'(g) - head_idx;
  end

  // Per load: scan older stores for unknown addresses and the youngest match.
  for (genvar i = 0; i < DEPTH; i++) begin : g_load
    logic             blk, hit;
    logic [PTR_W-1:0] best, best_age;

    always_comb begin
      blk      = 1'b0;
      hit      = 1'b0;
      best     = '0;
      best_age = '0;
      for (int j = 0; j < DEPTH; j++) begin
        if ((j != i) && valid[j] && is_st[j] && (age[j] < age[i])) begin
          if (!addr_v[j]) begin
            blk = 1'b1;
          end else if ((addr[j] == addr[i]) && (!hit || (age[j] > best_age))) begin
            hit      = 1'b1;
            best     = PTR_W'(j);
            best_age = age[j];
          end
        end
      end
    end

    assign blocked[i] = blk;
    assign matched[i] = hit;
    assign src[i]     = best;
    assign ready[i]   = valid[i] && !is_st[i] && addr_v[i] && !done[i] && !blk &&
                        (!hit || data_v[best]);
  end

  // Oldest ready load wins.
  always_comb begin
    logic             found;
    logic [PTR_W-1:0] probe;
    found   = 1'b0;
    sel_idx = '0;
    for (int k = 0; k < DEPTH; k++) begin
      probe = head_idx + PTR_W'(k);
      if (!found && ready[probe]) begin
        found   = 1'b1;
        sel_idx = probe;
      end
    end
    if (!found)                act = ACT_NONE;
    else if (matched[sel_idx]) act = ACT_FWD;
    else                       act = ACT_ISSUE;
  end

  assign sel_addr = addr[sel_idx];
  assign sel_data = data[src[sel_idx]];
endmodule

// File: rtl/mem_order_queue.sv
module mem_order_queue #(
  parameter int WINDOW = 64,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  localparam int DEPTH = WINDOW / 2,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic              alloc_is_store,
  output logic [PTR_W-1:0]  alloc_idx,
  output logic              full,
  output logic              empty,
  input  logic              addr_wb_valid,
  input  logic [PTR_W-1:0]  addr_wb_idx,
  input  logic [ADDR_W-1:0] addr_wb_addr,
  input  logic              data_wb_valid,
  input  logic [PTR_W-1:0]  data_wb_idx,
  input  logic [DATA_W-1:0] data_wb_data,
  output logic              ld_iss_valid,
  output logic [PTR_W-1:0]  ld_iss_idx,
  output logic [ADDR_W-1:0] ld_iss_addr,
  input  logic              ld_iss_ready,
  output logic              fwd_valid,
  output logic [PTR_W-1:0]  fwd_idx,
  output logic [DATA_W-1:0] fwd_data,
  input  logic              commit_valid,
  output logic              st_wr_valid,
  output logic [ADDR_W-1:0] st_wr_addr,
  output logic [DATA_W-1:0] st_wr_data,
  input  logic              flush_valid,
  input  logic [PTR_W-1:0]  flush_idx
);
  import mq_pkg::*;

  logic [PTR_W:0]    head_q, tail_q;
  logic [PTR_W-1:0]  head_idx, done_idx, sel_idx;
  logic [DEPTH-1:0]  v_q, st_q, av_q, dv_q, dn_q, clr_mask;
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [ADDR_W-1:0] sel_addr;
  logic [DATA_W-1:0] sel_data;
  logic              flush_en, alloc_en, retire_en, head_ok, done_en;
  mq_act_e           act;

  assign head_idx  = head_q[PTR_W-1:0];
  assign alloc_idx = tail_q[PTR_W-1:0];

  assign flush_en  = flush_valid && v_q[flush_idx];
  assign alloc_en  = alloc_valid && !full && !flush_en;
  assign head_ok   = v_q[head_idx] &&
                     (st_q[head_idx] ? (av_q[head_idx] && dv_q[head_idx]) : dn_q[head_idx]);
  assign retire_en = commit_valid && !flush_en && head_ok;

  assign st_wr_valid = retire_en && st_q[head_idx];
  assign st_wr_addr  = addr_q[head_idx];
  assign st_wr_data  = data_q[head_idx];

  assign ld_iss_valid = (act == ACT_ISSUE) && !flush_en;
  assign ld_iss_idx   = sel_idx;
  assign ld_iss_addr  = sel_addr;
  assign fwd_valid    = (act == ACT_FWD) && !flush_en;
  assign fwd_idx      = sel_idx;
  assign fwd_data     = sel_data;
  assign done_en      = fwd_valid || (ld_iss_valid && ld_iss_ready);
  assign done_idx     = sel_idx;

  for (genvar i = 0; i < DEPTH; i++) begin : g_clr
    assign clr_mask[i] = flush_en && v_q[i] &&
                         ((PTR_W'(i) - head_idx) > (flush_idx - head_idx));
  end

  mq_ptr_ctl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (alloc_en),
    .pop       (retire_en),
    .flush_en  (flush_en),
    .flush_idx (flush_idx),
    .head_q    (head_q),
    .tail_q    (tail_q),
    .full      (full),
    .empty     (empty)
  );

  mq_entry_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_slots (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_en   (alloc_en),
    .alloc_idx  (alloc_idx),
    .alloc_st   (alloc_is_store),
    .wa_en      (addr_wb_valid),
    .wa_idx     (addr_wb_idx),
    .wa_addr    (addr_wb_addr),
    .wd_en      (data_wb_valid),
    .wd_idx     (data_wb_idx),
    .wd_data    (data_wb_data),
    .done_en    (done_en),
    .done_idx   (done_idx),
    .retire_en  (retire_en),
    .retire_idx (head_idx),
    .clr_mask   (clr_mask),
    .valid_o    (v_q),
    .store_o    (st_q),
    .addr_v_o   (av_q),
    .data_v_o   (dv_q),
    .done_o     (dn_q),
    .addr_o     (addr_q),
    .data_o     (data_q)
  );

  mq_order_check #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_order (
    .head_idx (head_idx),
    .valid    (v_q),
    .is_st    (st_q),
    .addr_v   (av_q),
    .data_v   (dv_q),
    .done     (dn_q),
    .addr     (addr_q),
    .data     (data_q),
    .act      (act),
    .sel_idx  (sel_idx),
    .sel_addr (sel_addr),
    .sel_data (sel_data)
  );
endmodule

// File: rtl/mem_order_queue_chk.sv
module mem_order_queue_chk #(
  parameter int DEPTH = 32,
  parameter int PTR_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DEPTH-1:0] valid_q,
  input logic [DEPTH-1:0] is_st,
  input logic [DEPTH-1:0] done_q,
  input logic [PTR_W:0]   head_q,
  input logic [PTR_W:0]   tail_q,
  input logic             full,
  input logic             empty,
  input logic             ld_iss_valid,
  input logic [PTR_W-1:0] ld_iss_idx,
  input logic             fwd_valid,
  input logic [PTR_W-1:0] fwd_idx,
  input logic             st_wr_valid,
  input logic             flush_valid,
  input logic [PTR_W-1:0] flush_idx
);
  logic [PTR_W:0] occ;
  assign occ = tail_q - head_q;

  AST_OCCUPANCY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(valid_q) == int'(occ)); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= (PTR_W+1)'(DEPTH)); // R1
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R1
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_iss_valid && fwd_valid)); // R7
  AST_ISSUE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    ld_iss_valid |-> (valid_q[ld_iss_idx] && !is_st[ld_iss_idx] && !done_q[ld_iss_idx])); // R4
  AST_FWD_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |=> done_q[$past(fwd_idx)]); // R5
  AST_STORE_AT_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr_valid |=> (head_q == ($past(head_q) + 1'b1))); // R8
  AST_FLUSH_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_valid && valid_q[flush_idx]) |=> (tail_q[PTR_W-1:0] == ($past(flush_idx) + 1'b1))); // R9
endmodule

bind mem_order_queue mem_order_queue_chk #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .valid_q      (v_q),
  .is_st        (st_q),
  .done_q       (dn_q),
  .head_q       (head_q),
  .tail_q       (tail_q),
  .full         (full),
  .empty        (empty),
  .ld_iss_valid (ld_iss_valid),
  .ld_iss_idx   (ld_iss_idx),
  .fwd_valid    (fwd_valid),
  .fwd_idx      (fwd_idx),
  .st_wr_valid  (st_wr_valid),
  .flush_valid  (flush_valid),
  .flush_idx    (flush_idx)
);

// File: tb/mem_order_queue_bench.sv
`timescale 1ns/1ps
module mem_order_queue_bench;
  localparam int WINDOW = 8;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int PW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          alloc_valid = 1'b0, alloc_is_store = 1'b0;
  logic [PW-1:0] alloc_idx;
  logic          full, empty;
  logic          addr_wb_valid = 1'b0;
  logic [PW-1:0] addr_wb_idx = '0;
  logic [AW-1:0] addr_wb_addr = '0;
  logic          data_wb_valid = 1'b0;
  logic [PW-1:0] data_wb_idx = '0;
  logic [DW-1:0] data_wb_data = '0;
  logic          ld_iss_valid;
  logic [PW-1:0] ld_iss_idx;
  logic [AW-1:0] ld_iss_addr;
  logic          ld_iss_ready = 1'b0;
  logic          fwd_valid;
  logic [PW-1:0] fwd_idx;
  logic [DW-1:0] fwd_data;
  logic          commit_valid = 1'b0;
  logic          st_wr_valid;
  logic [AW-1:0] st_wr_addr;
  logic [DW-1:0] st_wr_data;
  logic          flush_valid = 1'b0;
  logic [PW-1:0] flush_idx = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  mem_order_queue #(.WINDOW(WINDOW), .ADDR_W(AW), .DATA_W(DW)) u_mem_order_queue (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
    alloc_valid   = 1'b0;
    addr_wb_valid = 1'b0;
    data_wb_valid = 1'b0;
    commit_valid  = 1'b0;
    flush_valid   = 1'b0;
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    ld_iss_ready = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
  endtask

  task automatic alloc_op(input logic st, input int exp_idx, input string req);
    alloc_valid = 1'b1;
    alloc_is_store = st;
    @(negedge clk);
    chk(req, 32'(alloc_idx), 32'(exp_idx));
    tick();
  endtask

  task automatic wa_op(input int idx, input logic [AW-1:0] a);
    addr_wb_valid = 1'b1;
    addr_wb_idx = PW'(idx);
    addr_wb_addr = a;
    tick();
  endtask

  task automatic wd_op(input int idx, input logic [DW-1:0] d);
    data_wb_valid = 1'b1;
    data_wb_idx = PW'(idx);
    data_wb_data = d;
    tick();
  endtask

  task automatic quiet(input string req);
    @(negedge clk);
    chk({req, " no issue"}, 32'(ld_iss_valid), 0);
    chk({req, " no forward"}, 32'(fwd_valid), 0);
  endtask

  task automatic commit_op(input logic exp_st, input logic [AW-1:0] ea, input logic [DW-1:0] ed);
    commit_valid = 1'b1;
    @(negedge clk);
    chk("R8 store write strobe", 32'(st_wr_valid), 32'(exp_st));
    if (exp_st) begin
      chk("R8 store write addr", 32'(st_wr_addr), 32'(ea));
      chk("R8 store write data", 32'(st_wr_data), 32'(ed));
    end
    tick();
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // Reset state and full/ignored allocation (R1), ignored commit (R8)
    do_reset();
    @(negedge clk);
    chk("R1 empty after reset", 32'(empty), 1);
    chk("R1 not full after reset", 32'(full), 0);
    tick();
    for (int k = 0; k < 4; k++) alloc_op(1'b0, k, "R1 slot order");
    @(negedge clk);
    chk("R1 full", 32'(full), 1);
    chk("R1 not empty", 32'(empty), 0);
    tick();
    alloc_op(1'b0, 0, "R1 tail while full");
    commit_op(1'b0, '0, '0);
    @(negedge clk);
    chk("R1 R8 still full after ignored ops", 32'(full), 1);
    tick();

    // Dropped writeback (R2) and oldest-first selection (R7)
    do_reset();
    wa_op(2, 8'h77);
    alloc_op(1'b0, 0, "R1 alloc");
    alloc_op(1'b0, 1, "R1 alloc");
    alloc_op(1'b0, 2, "R1 alloc");
    wa_op(1, 8'h21);
    wa_op(0, 8'h20);
    ld_iss_ready = 1'b1;
    @(negedge clk);
    chk("R7 oldest first valid", 32'(ld_iss_valid), 1);
    chk("R7 oldest first idx", 32'(ld_iss_idx), 0);
    chk("R4 issue addr", 32'(ld_iss_addr), 32'h20);
    tick();
    @(negedge clk);
    chk("R7 second load idx", 32'(ld_iss_idx), 1);
    chk("R4 second addr", 32'(ld_iss_addr), 32'h21);
    tick();
    quiet("R2 slot written while free");
    tick();
    ld_iss_ready = 1'b0;

    // Younger store ignored (R10), flush (R9)
    do_reset();
    alloc_op(1'b0, 0, "R1 alloc");
    alloc_op(1'b1, 1, "R1 alloc");
    alloc_op(1'b0, 2, "R1 alloc");
    alloc_op(1'b1, 3, "R1 alloc");
    wa_op(0, 8'h40);
    @(negedge clk);
    chk("R10 younger unknown store no block", 32'(ld_iss_valid), 1);
    tick();
    wa_op(1, 8'h40);
    @(negedge clk);
    chk("R10 younger equal store no forward", 32'(fwd_valid), 0);
    chk("R10 load still issued", 32'(ld_iss_valid), 1);
    tick();
    flush_valid = 1'b1;
    flush_idx = 2'd1;
    @(negedge clk);
    chk("R9 issue suppressed during flush", 32'(ld_iss_valid), 0);
    tick();
    @(negedge clk);
    chk("R9 tail after flush", 32'(alloc_idx), 2);
    chk("R9 not full after flush", 32'(full), 0);
    tick();
    flush_valid = 1'b1;
    flush_idx = 2'd3;
    tick();
    @(negedge clk);
    chk("R9 flush of free slot ignored", 32'(alloc_idx), 2);
    chk("R9 surviving load still offered", 32'(ld_iss_valid), 1);
    tick();

    // Store retire needs data (R8)
    do_reset();
    alloc_op(1'b1, 0, "R1 alloc");
    wa_op(0, 8'h22);
    commit_op(1'b0, '0, '0);
    @(negedge clk);
    chk("R8 ignored commit keeps entry", 32'(empty), 0);
    tick();
    wd_op(0, 16'hBEEF);
    commit_op(1'b1, 8'h22, 16'hBEEF);
    @(negedge clk);
    chk("R8 empty after retire", 32'(empty), 1);
    tick();

    // Sweep: three older stores, each matching the load or not (R3-R6, R8)
    for (int p = 0; p < 8; p++) begin
      int kmax;
      kmax = p[2] ? 2 : (p[1] ? 1 : 0);
      do_reset();
      for (int k = 0; k < 3; k++) alloc_op(1'b1, k, "R1 alloc");
      alloc_op(1'b0, 3, "R1 alloc");
      wa_op(3, 8'h40);
      for (int k = 0; k < 3; k++) begin
        quiet("R3 older address unknown");
        tick();
        wa_op(k, p[k] ? 8'h40 : 8'(8'h50 + k));
      end
      if (p == 0) begin
        @(negedge clk);
        chk("R4 no match offered", 32'(ld_iss_valid), 1);
        chk("R4 offered idx", 32'(ld_iss_idx), 3);
        chk("R4 offered addr", 32'(ld_iss_addr), 32'h40);
        chk("R4 no forward", 32'(fwd_valid), 0);
        tick();
        @(negedge clk);
        chk("R4 offer held without ready", 32'(ld_iss_valid), 1);
        tick();
        ld_iss_ready = 1'b1;
        @(negedge clk);
        chk("R4 accepted", 32'(ld_iss_valid), 1);
        tick();
        ld_iss_ready = 1'b0;
        quiet("R4 complete after accept");
        tick();
        for (int k = 0; k < 3; k++) wd_op(k, 16'h1000 + 16'(k) + 16'(p << 4));
      end else begin
        quiet("R6 matching store without data");
        tick();
        for (int k = 0; k < 3; k++)
          if (k != kmax) wd_op(k, 16'h1000 + 16'(k) + 16'(p << 4));
        quiet("R6 youngest match still without data");
        tick();
        wd_op(kmax, 16'h1000 + 16'(kmax) + 16'(p << 4));
        @(negedge clk);
        chk("R5 forward valid", 32'(fwd_valid), 1);
        chk("R5 forward idx", 32'(fwd_idx), 3);
        chk("R5 youngest match data", 32'(fwd_data), 32'(16'h1000 + 16'(kmax) + 16'(p << 4)));
        chk("R5 never offered to cache", 32'(ld_iss_valid), 0);
        tick();
        quiet("R5 forward completes once");
        tick();
      end
      for (int k = 0; k < 3; k++)
        commit_op(1'b1, p[k] ? 8'h40 : 8'(8'h50 + k), 16'h1000 + 16'(k) + 16'(p << 4));
      commit_op(1'b0, '0, '0);
      @(negedge clk);
      chk("R8 empty after all retire", 32'(empty), 1);
      tick();
    end

    finish_run();
  end
endmodule